// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus (IEEE 802.3 Clause 22 frames). It derives the management clock (MDC) from the system clock through a 16-bit divider. It also sends read and write frames that a host requests through a single packed access word. While the engine is enabled and no host request is waiting, it polls every one of the 32 PHY addresses in turn. The result of each poll is kept in a presence bitmask.

Host software starts a frame by writing the access word with its start bit set, then polls that bit until hardware clears it. After a read it checks the acknowledge bit and takes the data. The background poll never breaks off a frame already on the wire, so a host request can wait for at most one poll frame. A bypass mode hands the clock, output-enable and data-out pins to plain register bits, and gives back the sampled pin level, so that software can drive the bus itself.

Registers sit at word offsets on a 3-bit address: 0 control, 1 access, 2 presence, 3 mode, 4 bypass pins. Other offsets read as zero. Reads are combinational. A write takes effect at the clock edge where `reg_wr_i` is high.

Top module: `mdio_master`

## Requirements
- R1: Control register (offset 0) has idle status in bit 31, enable in bit 30 and the clock divider in bits 15:0; after reset it reads 0x8000_0000.
- R2: While running, MDC has a period of max(divider,1)+1 system clocks (a divider of 0 behaves as 1); MDC stays low while the engine is stopped.
- R3: Access word (offset 1): bit 31 start/busy, bit 30 write(1)/read(0), bit 29 acknowledge, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data; a write with bit 31 set starts a frame, bit 31 stays set until that frame ends and is then cleared by hardware.
- R4: A write frame is 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then 16 data bits, all MSB first; MDIO changes on the falling MDC edge.
- R5: A read frame uses opcode 10 and releases MDIO from the turnaround onward; the acknowledge bit is set only when the PHY drives the second turnaround bit low, sampled on the rising MDC edge. Bits 15:0 then hold the 16 bits read. With no PHY responding, acknowledge is 0 and, with the line pulled up, the data reads 0xFFFF. After a write frame, acknowledge reads 0.
- R6: While enabled and no host request is waiting, the engine reads register 1 of the PHY addresses 0,1,...,31 in a round-robin loop. Bit n of the presence register (offset 2) holds the acknowledge of the last poll of address n; reset value 0.
- R7: A host request waits only for a frame already in progress and takes precedence at the next frame boundary, so it completes within two frame times of its start write.
- R8: A write to the access word while bit 31 is set is ignored.
- R9: Clearing enable lets a frame in progress finish and starts no further frames; idle reads 1 only when the engine is stopped and no frame is on the wire.
- R10: Mode register (offset 3) bit 31 selects bypass. In bypass the bypass register (offset 4) drives MDC from bit 2, the MDIO output enable from bit 1 and MDIO out from bit 0. No engine frame starts in bypass. Reading offset 4 returns the MDIO pin, registered once, in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pin level |

## Verification
A PHY model on the bench decodes every frame from the pins. It answers only at three addresses, from a per-register memory, so read results from present and absent PHYs show whether the turnaround acknowledge and the data capture work. The table of host operations runs a write and then a read-back of the same register. This separates real frame decoding from constant data. It also reads from absent addresses, which must come back with no acknowledge and 0xFFFF. Directed cases measure the MDC period at dividers 5 and 0, check the presence mask after a full poll, issue a second start while one is pending, stop the engine while a frame is running, and drive each bypass pin bit by itself with the pin forced against its pull-up.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DAT_W      = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_AW + REG_AW + 2 + DAT_W;
  localparam int TA_IDX     = PRE_BITS + 2 + 2 + PHY_AW + REG_AW;
  localparam int NUM_PHY    = 1 << PHY_AW;

  typedef enum logic [2:0] {
    OFS_CTRL   = 3'd0,
    OFS_USER   = 3'd1,
    OFS_ALIVE  = 3'd2,
    OFS_MODE   = 3'd3,
    OFS_MANUAL = 3'd4
  } reg_ofs_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              wr,
    input logic [PHY_AW-1:0] phy,
    input logic [REG_AW-1:0] ra,
    input logic [DAT_W-1:0]  d
  );
    return {{PRE_BITS{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
            (wr ? 2'b10 : 2'b11), (wr ? d : {DAT_W{1'b1}})};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [DIV_W:0]   ONE_W   = 1;
  localparam logic [DIV_W-1:0] CNT_ONE = 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   deff_w, half_w;
  logic             mdc_q;

  assign deff_w = (div_i == '0) ? ONE_W : {1'b0, div_i};
  assign half_w = (deff_w + ONE_W) >> 1;
  assign rise_o = run_i && (cnt_q == '0);
  assign fall_o = run_i && (cnt_q == half_w[DIV_W-1:0]);
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q >= deff_w[DIV_W-1:0]) ? '0 : cnt_q + CNT_ONE;
      if (rise_o) mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end

  // R2
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_q);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  start_i,
  input  logic                  rd_i,
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mdo_o,
  output logic                  oe_o,
  output logic                  ack_o,
  output logic [DAT_W-1:0]      rdata_o
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA0     = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] TA1     = IDX_W'(TA_IDX + 1);
  localparam logic [IDX_W-1:0] IDX_ONE = 1;

  logic                  busy_q, rd_q, out_q, ack_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [DAT_W-1:0]      rdat_q;

  assign done_o  = fall_i && busy_q && (idx_q == LAST);
  assign busy_o  = busy_q;
  assign mdo_o   = out_q;
  assign oe_o    = busy_q && !(rd_q && (idx_q >= TA0));
  assign ack_o   = ack_q;
  assign rdata_o = rdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      out_q  <= 1'b0;
      ack_q  <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rdat_q <= '0;
    end else begin
      if (fall_i && (!busy_q || idx_q == LAST)) begin
        if (start_i) begin
          busy_q <= 1'b1;
          rd_q   <= rd_i;
          idx_q  <= '0;
          out_q  <= word_i[FRAME_BITS-1];
          sh_q   <= word_i << 1;
          ack_q  <= 1'b0;
        end else begin
          busy_q <= 1'b0;
          out_q  <= 1'b0;
        end
      end else if (fall_i && busy_q) begin
        idx_q <= idx_q + IDX_ONE;
        out_q <= sh_q[FRAME_BITS-1];
        sh_q  <= sh_q << 1;
      end
      // sample on rising MDC
      if (rise_i && busy_q && rd_q) begin
        if (idx_q == TA1) ack_q <= !mdio_i;
        else if (idx_q > TA1) rdat_q <= {rdat_q[DAT_W-2:0], mdio_i};
      end
    end
  end

  // R4
  preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> out_q);
  // R4
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(idx_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SCAN_REG = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam logic [PHY_AW-1:0] SCAN_ONE = 1;
  localparam logic [REG_AW-1:0] SCAN_RA  = REG_AW'(SCAN_REG);

  logic              en_q, go_q, wr_q, ack_q, cur_host_q, manual_q, pin_q;
  logic [DIV_W-1:0]  div_q;
  logic [PHY_AW-1:0] phy_q, scan_addr_q, scan_next;
  logic [REG_AW-1:0] ra_q;
  logic [DAT_W-1:0]  data_q;
  logic [NUM_PHY-1:0] alive_q;
  logic [2:0]        man_q;

  logic gen_mdc, rise, fall, run;
  logic frm_busy, frm_done, frm_mdo, frm_oe, frm_ack;
  logic [DAT_W-1:0] frm_rdata;
  logic can_run, host_req, start_evt, idle, scan_done;
  logic [FRAME_BITS-1:0] word;
  logic unused_w;

  assign unused_w  = ^reg_wdata_i[29:26];
  assign run       = en_q || frm_busy;
  assign can_run   = en_q && !manual_q;
  assign host_req  = go_q && !(frm_done && cur_host_q);
  assign start_evt = fall && can_run && (!frm_busy || frm_done);
  assign scan_done = frm_done && !cur_host_q;
  assign scan_next = scan_done ? scan_addr_q + SCAN_ONE : scan_addr_q;
  assign idle      = !en_q && !frm_busy;
  assign word      = host_req ? build_frame(wr_q, phy_q, ra_q, data_q)
                              : build_frame(1'b0, scan_next, SCAN_RA, '0);

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run), .div_i (div_q),
    .mdc_o (gen_mdc), .rise_o (rise), .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i (clk_i), .rst_ni (rst_ni), .rise_i (rise), .fall_i (fall),
    .start_i (can_run), .rd_i (host_req ? !wr_q : 1'b1), .word_i (word),
    .mdio_i (mdio_i), .busy_o (frm_busy), .done_o (frm_done),
    .mdo_o (frm_mdo), .oe_o (frm_oe), .ack_o (frm_ack), .rdata_o (frm_rdata)
  );

  assign mdc_o     = manual_q ? man_q[2] : gen_mdc;
  assign mdio_oe_o = manual_q ? man_q[1] : frm_oe;
  assign mdio_o    = manual_q ? man_q[0] : frm_mdo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      div_q       <= '0;
      go_q        <= 1'b0;
      wr_q        <= 1'b0;
      ack_q       <= 1'b0;
      phy_q       <= '0;
      ra_q        <= '0;
      data_q      <= '0;
      alive_q     <= '0;
      scan_addr_q <= '0;
      cur_host_q  <= 1'b0;
      manual_q    <= 1'b0;
      man_q       <= '0;
      pin_q       <= 1'b0;
    end else begin
      pin_q <= mdio_i;
      if (start_evt) cur_host_q <= host_req;
      if (frm_done) begin
        if (cur_host_q) begin
          go_q <= 1'b0;
          if (!wr_q) begin
            ack_q  <= frm_ack;
            data_q <= frm_rdata;
          end
        end else begin
          alive_q[scan_addr_q] <= frm_ack;
        end
      end
      scan_addr_q <= scan_next;
      if (reg_wr_i) begin
        case (reg_addr_i)
          OFS_CTRL: begin
            en_q  <= reg_wdata_i[30];
            div_q <= reg_wdata_i[DIV_W-1:0];
          end
          OFS_USER: if (!go_q && reg_wdata_i[31]) begin
            go_q   <= 1'b1;
            wr_q   <= reg_wdata_i[30];
            ack_q  <= 1'b0;
            ra_q   <= reg_wdata_i[25:21];
            phy_q  <= reg_wdata_i[20:16];
            data_q <= reg_wdata_i[15:0];
          end
          OFS_MODE:   manual_q <= reg_wdata_i[31];
          OFS_MANUAL: man_q    <= reg_wdata_i[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFS_CTRL:   reg_rdata_o = {idle, en_q, {(30-DIV_W){1'b0}}, div_q};
      OFS_USER:   reg_rdata_o = {go_q, wr_q, ack_q, 3'b000, ra_q, phy_q, data_q};
      OFS_ALIVE:  reg_rdata_o = alive_q;
      OFS_MODE:   reg_rdata_o = {manual_q, 31'd0};
      OFS_MANUAL: reg_rdata_o = {29'd0, man_q[2:1], pin_q};
      default:    reg_rdata_o = '0;
    endcase
  end

  // R3
  go_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(go_q) |-> $past(frm_done && cur_host_q));
  // R6
  alive_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_done |=> $stable(alive_q));
  // R9
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frm_busy) |-> $past(en_q && !manual_q));
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam logic [31:0] PRESENT = 32'h0000_8012; // PHYs 1, 4, 15
  localparam int FRAME_CLK = 128;                  // 64 bits at divider 1

  // {wr, phy, reg, data, exp_ack, exp_data}
  localparam logic [43:0] VEC [7] = '{
    {1'b1, 5'd1,  5'd3,  16'h1234, 1'b0, 16'h1234},
    {1'b0, 5'd1,  5'd3,  16'h0000, 1'b1, 16'h1234},
    {1'b0, 5'd4,  5'd0,  16'h0000, 1'b1, 16'h5A80},
    {1'b0, 5'd2,  5'd5,  16'h0000, 1'b0, 16'hFFFF},
    {1'b1, 5'd15, 5'd31, 16'hC3A5, 1'b0, 16'hC3A5},
    {1'b0, 5'd15, 5'd31, 16'h0000, 1'b1, 16'hC3A5},
    {1'b0, 5'd31, 5'd31, 16'h0000, 1'b0, 16'hFFFF}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdo, moe;
  logic phy_drv = 0, phy_val = 0, frc_en = 0, frc_val = 0;
  wire mdio_line = moe ? mdo : (frc_en ? frc_val : (phy_drv ? phy_val : 1'b1));

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio_master uut (
    .clk_i (clk), .rst_ni (rst_n), .reg_wr_i (reg_wr), .reg_addr_i (reg_addr),
    .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata), .mdc_o (mdc),
    .mdio_o (mdo), .mdio_oe_o (moe), .mdio_i (mdio_line)
  );

  // PHY model
  logic [15:0] phy_mem [32][32];
  int ones = 0, pos = 0, frame_cnt = 0, wr_cnt = 0;
  bit inframe = 0;
  logic [1:0] f_op;
  logic [4:0] f_phy, f_reg, cap_phy, cap_reg;
  logic [15:0] f_dat, cap_dat;

  initial
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) phy_mem[p][r] = 16'h5A00 | 16'(p << 5) | 16'(r);

  always @(posedge mdc) begin
    if (!inframe) begin
      if (moe && mdio_line) ones++;
      else if (moe && !mdio_line && ones >= 32) begin inframe = 1; pos = 1; ones = 0; end
      else ones = 0;
    end else begin
      if (pos == 2 || pos == 3) f_op = {f_op[0], mdio_line};
      else if (pos >= 4 && pos <= 8) f_phy = {f_phy[3:0], mdio_line};
      else if (pos >= 9 && pos <= 13) f_reg = {f_reg[3:0], mdio_line};
      else if (pos >= 16) f_dat = {f_dat[14:0], mdio_line};
      if (pos == 31) begin
        inframe = 0; ones = 0; frame_cnt++;
        if (f_op == 2'b01) begin
          wr_cnt++; cap_phy = f_phy; cap_reg = f_reg; cap_dat = f_dat;
          if (PRESENT[f_phy]) phy_mem[f_phy][f_reg] = f_dat;
        end
      end
      pos++;
    end
  end

  always @(negedge mdc) begin
    phy_drv = 0;
    if (inframe && f_op == 2'b10 && PRESENT[f_phy]) begin
      if (pos == 15) begin phy_drv = 1; phy_val = 0; end
      else if (pos >= 16 && pos <= 31) begin
        phy_drv = 1; phy_val = phy_mem[f_phy][f_reg][31 - pos];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_go(output int cyc);
    logic [31:0] v;
    cyc = 0;
    do begin rd_reg(3'd1, v); cyc++; end while (v[31] && cyc < 2000);
  endtask

  task automatic mdc_period(output int clks);
    realtime t0;
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); clks = int'(($realtime - t0) / 5.0);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc, per, fc, wc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(3'd0, v); check("R1 reset ctrl", v, 32'h8000_0000);
    rd_reg(3'd1, v); check("R3 reset access", v, 32'h0);
    rd_reg(3'd2, v); check("R6 reset alive", v, 32'h0);
    check("R2 reset mdc/oe", {30'd0, mdc, moe}, 32'h0);

    // R2 divider
    wr_reg(3'd0, 32'h4000_0005);
    rd_reg(3'd0, v); check("R1 ctrl readback", v, 32'h4000_0005);
    mdc_period(per); check("R2 period div5", per, 6);
    wr_reg(3'd0, 32'h4000_0000);
    repeat (20) @(negedge clk);
    mdc_period(per); check("R2 period div0", per, 2);

    // R6 full scan at divider 1
    wr_reg(3'd0, 32'h4000_0001);
    repeat (33 * FRAME_CLK + 300) @(negedge clk);
    rd_reg(3'd2, v); check("R6 alive mask", v, PRESENT);

    // R3 R4 R5 R7 table
    for (int i = 0; i < 7; i++) begin
      logic w; logic [4:0] ph, ra; logic [15:0] dd, ed; logic ea;
      {w, ph, ra, dd, ea, ed} = VEC[i];
      wc = wr_cnt;
      wr_reg(3'd1, {1'b1, w, 1'b0, 3'b000, ra, ph, dd});
      wait_go(cyc);
      check("R7 latency within two frames", 32'(cyc <= 2 * FRAME_CLK + 10), 32'h1);
      rd_reg(3'd1, v);
      check("R3 go cleared", v[31], 1'b0);
      check("R5 ack", v[29], ea);
      if (w) begin
        check("R4 write frame seen", wr_cnt - wc, 1);
        check("R4 write fields", {cap_phy, cap_reg, cap_dat}, {ph, ra, dd});
      end else begin
        check("R5 read data", v[15:0], ed);
      end
    end

    // R8 second start while busy is ignored
    wr_reg(3'd1, {1'b1, 1'b0, 1'b0, 3'b000, 5'd0, 5'd4, 16'h0});
    wr_reg(3'd1, {1'b1, 1'b0, 1'b0, 3'b000, 5'd3, 5'd1, 16'h0});
    wait_go(cyc);
    rd_reg(3'd1, v);
    check("R8 phy field kept", v[20:16], 5'd4);
    check("R8 data of first request", v[15:0], 16'h5A80);

    // R9 stop
    wr_reg(3'd0, 32'h0000_0001);
    cyc = 0;
    do begin rd_reg(3'd0, v); cyc++; end while (!v[31] && cyc < 300);
    check("R9 idle within one frame", 32'(cyc <= FRAME_CLK + 10), 32'h1);
    check("R9 ctrl stopped", v, 32'h8000_0001);
    fc = frame_cnt;
    repeat (400) @(negedge clk);
    check("R9 no frames after stop", frame_cnt - fc, 0);
    check("R2 mdc low when stopped", mdc, 1'b0);

    // R10 bypass
    wr_reg(3'd3, 32'h8000_0000);
    wr_reg(3'd0, 32'h4000_0001);
    wr_reg(3'd4, 32'h0000_0006);
    @(negedge clk);
    check("R10 pins 110", {mdc, moe, mdo}, 3'b110);
    wr_reg(3'd4, 32'h0000_0001);
    @(negedge clk);
    check("R10 pins 001", {mdc, moe, mdo}, 3'b001);
    fc = frame_cnt;
    repeat (300) @(negedge clk);
    check("R10 no engine frames", frame_cnt - fc, 0);
    check("R10 mdc held by bit 2", mdc, 1'b0);
    frc_en = 1; frc_val = 0;
    repeat (2) @(negedge clk);
    rd_reg(3'd4, v); check("R10 pin low readback", v[0], 1'b0);
    frc_val = 1;
    repeat (2) @(negedge clk);
    rd_reg(3'd4, v); check("R10 pin high readback", v[0], 1'b1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule